// File: doc/BRIEF.md
# Instruction Cache Invalidation and Lock-Clear Sequencer

This block holds the control and status word of an instruction cache and drives a sequencer that walks the cache arrays on request. Software writes one 32-bit register. Setting the invalidate bit makes hardware clear the valid bit, the lock bit and the check bits of every line. Setting the lock-clear bit makes hardware clear only the lock bits. Either bit falls back to 0 by itself when the walk ends. The walk advances one set per clock and writes every way of that set together, through a set-index and way-enable write port.

An abort input stops a running walk on the next clock edge. When that happens, a sticky status bit records the abort and stays set until software writes 0 to it. The check bits written during an invalidation follow a detection-type bit, which is captured when the walk starts. A configuration input selects the array geometry, and a read-only register bit reports it. In the narrow geometry the cache has 64 sets of 2 ways. In the wide geometry it has 32 sets of 4 ways.

Register bits use LSB-0 numbering: bit 0 cache enable, bit 1 invalidate, bit 2 abort status, bit 3 geometry (read-only), bit 8 lock-clear, bit 16 detection type. All other bits read as 0.

Top module: `icache_inval_ctrl`

## Requirements
- R1: After reset, every register bit reads 0 (with the geometry input at 0), and `busy`, `done`, `abort_flag` and `cache_en` are 0.
- R2: Writing 1 to bit 1 while idle starts an invalidation. `busy` is then high for exactly sets+2 cycles, and bit 1 reads 1 throughout that time. `done` pulses in the last busy cycle, and bit 1 reads 0 afterwards.
- R3: The walk writes each set of the geometry exactly once. With the geometry input at 1 it writes 32 sets with way-enable 4'b1111. With the geometry input at 0 it writes 64 sets with way-enable 4'b0011. Bit 3 reads back the geometry input.
- R4: Every invalidation write clears valid and lock and writes check bits. The check bits are all 0 when detection type (bit 16) is 0 and all 1 when it is 1. The value of bit 16 written together with the request applies to that walk, and later writes do not change it mid-walk.
- R5: Writing 0 to bit 1 or bit 8 during a walk is ignored. Writing 1 to them during a walk does not restart or lengthen it.
- R6: Bit 0 is read/write and drives `cache_en`. An invalidation runs in the same way whether bit 0 is 0 or 1.
- R7: Writing 1 to bit 8 while idle starts a lock-clear walk. It has the same length and coverage as an invalidation, but it clears only lock bits and writes neither valid nor check bits. Bit 8 returns to 0 at the end.
- R8: A high `abort_req` during a walk ends it at the next edge. That edge sets bit 2, clears bits 1 and 8, and suppresses `done`, and no array writes follow. A high `abort_req` while idle changes nothing.
- R9: Bit 2 stays set until software writes 0 to it. Writing 1 to bit 2 leaves it unchanged.
- R10: If bits 1 and 8 are both written as 1 while idle, only the invalidation runs, and bit 8 stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr | input | 1 | Register write strobe |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data |
| abort_req | input | 1 | Request to abort a running walk |
| four_way_cfg | input | 1 | Geometry select: 1 = 32 sets x 4 ways, 0 = 64 sets x 2 ways |
| arr_we | output | 1 | Array write strobe |
| arr_set | output | 6 | Set index being written |
| arr_way_en | output | 4 | Ways written in this cycle |
| arr_clr_valid | output | 1 | Clear valid bits of the enabled ways |
| arr_clr_lock | output | 1 | Clear lock bits of the enabled ways |
| arr_chk_we | output | 1 | Write check bits of the enabled ways |
| arr_chk | output | 4 | Check-bit value to write |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse when a walk completes |
| abort_flag | output | 1 | Sticky abort status |
| cache_en | output | 1 | Cache enable |

## Verification
A wrong set counter or a wrong geometry latch shows up on the array port during the same walk, as a set that is skipped or repeated, a wrong way-enable, or a busy length other than sets+2. These are visible within 66 cycles of the request. A corrupted operation or detection-type latch appears on the very first array write as wrong clear or check-bit values. A lost or spurious abort state shows on `abort_flag` and on the register read one cycle after the abort edge, and it persists until software writes to the register.

// File: rtl/icinv_pkg.sv
package icinv_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned BIT_EN  = 0;
  localparam int unsigned BIT_INV = 1;
  localparam int unsigned BIT_ABT = 2;
  localparam int unsigned BIT_ORG = 3;
  localparam int unsigned BIT_FLC = 8;
  localparam int unsigned BIT_DT  = 16;

  typedef enum logic [1:0] {
    WS_IDLE   = 2'd0,
    WS_SETUP  = 2'd1,
    WS_WALK   = 2'd2,
    WS_FINISH = 2'd3
  } walk_state_e;

  typedef enum logic {
    OP_INVAL   = 1'b0,
    OP_LOCKCLR = 1'b1
  } walk_op_e;

  typedef struct packed {
    logic en;
    logic dtype;
    logic abt;
    logic inv;
    logic flc;
  } csr_fields_t;
endpackage

// File: rtl/icinv_rst_sync.sv
module icinv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/icinv_csr.sv
module icinv_csr
  import icinv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  logic             four_way,
  input  logic             walk_busy,
  input  logic             walk_done,
  input  logic             walk_abort,
  output logic             start_inv,
  output logic             start_flc,
  output logic [REG_W-1:0] rdata,
  output csr_fields_t      fields
);
  csr_fields_t cur_q, nxt;
  logic        upd;

  always_comb begin
    nxt       = cur_q;
    start_inv = wr_en && wdata[BIT_INV] && !walk_busy;
    start_flc = wr_en && wdata[BIT_FLC] && !wdata[BIT_INV] && !walk_busy;
    if (wr_en) begin
      nxt.en    = wdata[BIT_EN];
      nxt.dtype = wdata[BIT_DT];
      if (!wdata[BIT_ABT]) nxt.abt = 1'b0;
    end
    if (start_inv) nxt.inv = 1'b1;
    if (start_flc) nxt.flc = 1'b1;
    if (walk_done || walk_abort) begin
      nxt.inv = 1'b0;
      nxt.flc = 1'b0;
    end
    if (walk_abort) nxt.abt = 1'b1;
  end

  assign upd = wr_en || walk_done || walk_abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cur_q <= '0;
    else if (upd) cur_q <= nxt;
  end

  always_comb begin
    rdata          = '0;
    rdata[BIT_EN]  = cur_q.en;
    rdata[BIT_INV] = cur_q.inv;
    rdata[BIT_ABT] = cur_q.abt;
    rdata[BIT_ORG] = four_way;
    rdata[BIT_FLC] = cur_q.flc;
    rdata[BIT_DT]  = cur_q.dtype;
  end

  assign fields = cur_q;

  // R9
  abt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_q.abt && !(wr_en && !wdata[BIT_ABT]) |=> cur_q.abt);
  // R8
  abt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_abort |=> cur_q.abt && !cur_q.inv && !cur_q.flc);
  // R10
  op_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cur_q.inv, cur_q.flc}));
  // R2
  done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |=> !cur_q.inv && !cur_q.flc);
endmodule

// File: rtl/icinv_chkgen.sv
module icinv_chkgen #(
  parameter int unsigned CHK_W = 4
) (
  input  logic             wr,
  input  logic             dtype,
  output logic [CHK_W-1:0] chk
);
  for (genvar i = 0; i < CHK_W; i++) begin : g_bit
    assign chk[i] = wr & dtype;
  end
endmodule

// File: rtl/icinv_walker.sv
module icinv_walker
  import icinv_pkg::*;
#(
  parameter int unsigned SET_W    = 6,
  parameter int unsigned MAX_WAYS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_inv,
  input  logic                start_flc,
  input  logic                abort_req,
  input  logic                four_way,
  input  logic                dtype_in,
  output logic                busy,
  output logic                done,
  output logic                aborted,
  output logic                arr_we,
  output logic [SET_W-1:0]    arr_set,
  output logic [MAX_WAYS-1:0] arr_way_en,
  output logic                arr_clr_valid,
  output logic                arr_clr_lock,
  output logic                arr_chk_we,
  output logic                walk_dtype
);
  localparam logic [SET_W-1:0]    LAST_WIDE   = SET_W'((1 << (SET_W - 1)) - 1);
  localparam logic [SET_W-1:0]    LAST_NARROW = {SET_W{1'b1}};
  localparam logic [MAX_WAYS-1:0] NARROW_MASK = MAX_WAYS'((1 << (MAX_WAYS / 2)) - 1);

  walk_state_e     state_q, state_n;
  walk_op_e        op_q, op_n;
  logic            geo_q, geo_n;
  logic            dt_q, dt_n;
  logic [SET_W-1:0] set_q, set_n;
  logic [SET_W-1:0] last_set;
  logic            walk_ce;

  assign last_set = geo_q ? LAST_WIDE : LAST_NARROW;
  assign busy     = (state_q != WS_IDLE);
  assign aborted  = abort_req && busy;

  always_comb begin
    state_n = state_q;
    op_n    = op_q;
    geo_n   = geo_q;
    dt_n    = dt_q;
    set_n   = set_q;
    unique case (state_q)
      WS_IDLE: begin
        if (start_inv || start_flc) begin
          state_n = WS_SETUP;
          op_n    = start_inv ? OP_INVAL : OP_LOCKCLR;
          geo_n   = four_way;
          set_n   = '0;
        end
      end
      WS_SETUP: begin
        state_n = WS_WALK;
        dt_n    = dtype_in;
      end
      WS_WALK: begin
        if (set_q == last_set) state_n = WS_FINISH;
        else                   set_n   = set_q + 1'b1;
      end
      WS_FINISH: state_n = WS_IDLE;
      default:   state_n = WS_IDLE;
    endcase
    if (aborted) state_n = WS_IDLE;
  end

  assign walk_ce = busy || start_inv || start_flc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WS_IDLE;
      op_q    <= OP_INVAL;
      geo_q   <= 1'b0;
      dt_q    <= 1'b0;
      set_q   <= '0;
    end else if (walk_ce) begin
      state_q <= state_n;
      op_q    <= op_n;
      geo_q   <= geo_n;
      dt_q    <= dt_n;
      set_q   <= set_n;
    end
  end

  assign done          = (state_q == WS_FINISH) && !abort_req;
  assign arr_we        = (state_q == WS_WALK);
  assign arr_set       = set_q;
  assign arr_way_en    = arr_we ? (geo_q ? {MAX_WAYS{1'b1}} : NARROW_MASK) : '0;
  assign arr_clr_valid = arr_we && (op_q == OP_INVAL);
  assign arr_clr_lock  = arr_we;
  assign arr_chk_we    = arr_we && (op_q == OP_INVAL);
  assign walk_dtype    = dt_q;

  // R3
  set_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we && geo_q |-> set_q <= LAST_WIDE);
  // R8
  abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aborted |=> !busy && !arr_we);
  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  // R5
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we && !aborted && (set_q != last_set) |=> arr_we && (set_q != '0));
endmodule

// File: rtl/icache_inval_ctrl.sv
module icache_inval_ctrl
  import icinv_pkg::*;
#(
  parameter int unsigned SET_W    = 6,
  parameter int unsigned MAX_WAYS = 4,
  parameter int unsigned CHK_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                csr_wr,
  input  logic [REG_W-1:0]    csr_wdata,
  output logic [REG_W-1:0]    csr_rdata,
  input  logic                abort_req,
  input  logic                four_way_cfg,
  output logic                arr_we,
  output logic [SET_W-1:0]    arr_set,
  output logic [MAX_WAYS-1:0] arr_way_en,
  output logic                arr_clr_valid,
  output logic                arr_clr_lock,
  output logic                arr_chk_we,
  output logic [CHK_W-1:0]    arr_chk,
  output logic                busy,
  output logic                done,
  output logic                abort_flag,
  output logic                cache_en
);
  logic        rst_s_n;
  logic        start_inv, start_flc;
  logic        walk_abort, walk_dtype;
  csr_fields_t fields;

  icinv_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  icinv_csr i_csr (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .wr_en      (csr_wr),
    .wdata      (csr_wdata),
    .four_way   (four_way_cfg),
    .walk_busy  (busy),
    .walk_done  (done),
    .walk_abort (walk_abort),
    .start_inv  (start_inv),
    .start_flc  (start_flc),
    .rdata      (csr_rdata),
    .fields     (fields)
  );

  icinv_walker #(.SET_W(SET_W), .MAX_WAYS(MAX_WAYS)) i_walker (
    .clk           (clk),
    .rst_n         (rst_s_n),
    .start_inv     (start_inv),
    .start_flc     (start_flc),
    .abort_req     (abort_req),
    .four_way      (four_way_cfg),
    .dtype_in      (fields.dtype),
    .busy          (busy),
    .done          (done),
    .aborted       (walk_abort),
    .arr_we        (arr_we),
    .arr_set       (arr_set),
    .arr_way_en    (arr_way_en),
    .arr_clr_valid (arr_clr_valid),
    .arr_clr_lock  (arr_clr_lock),
    .arr_chk_we    (arr_chk_we),
    .walk_dtype    (walk_dtype)
  );

  icinv_chkgen #(.CHK_W(CHK_W)) i_chkgen (
    .wr    (arr_chk_we),
    .dtype (walk_dtype),
    .chk   (arr_chk)
  );

  assign abort_flag = fields.abt;
  assign cache_en   = fields.en;

  // R6
  en_follow_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    csr_wr |=> cache_en == $past(csr_wdata[BIT_EN]));
endmodule

// File: tb/test_icache_inval_ctrl.sv
module test_icache_inval_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        csr_wr;
  logic [31:0] csr_wdata;
  logic [31:0] csr_rdata;
  logic        abort_req;
  logic        four_way_cfg;
  logic        arr_we;
  logic [5:0]  arr_set;
  logic [3:0]  arr_way_en;
  logic        arr_clr_valid, arr_clr_lock, arr_chk_we;
  logic [3:0]  arr_chk;
  logic        busy, done, abort_flag, cache_en;

  int n_checks = 0;
  int n_errors = 0;

  always #2 clk = ~clk;

  icache_inval_ctrl i_icache_inval_ctrl (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .abort_req(abort_req), .four_way_cfg(four_way_cfg),
    .arr_we(arr_we), .arr_set(arr_set), .arr_way_en(arr_way_en),
    .arr_clr_valid(arr_clr_valid), .arr_clr_lock(arr_clr_lock),
    .arr_chk_we(arr_chk_we), .arr_chk(arr_chk), .busy(busy), .done(done),
    .abort_flag(abort_flag), .cache_en(cache_en)
  );

  // monitor, sampling at the falling edge
  int         n_busy, n_done, n_wr, n_cv, n_cl, n_cw, n_badmask, n_badchk;
  int         set_hits [64];
  logic [3:0] exp_mask;
  logic [3:0] exp_chk;

  always @(negedge clk) begin
    if (busy) n_busy++;
    if (done) n_done++;
    if (arr_we) begin
      n_wr++;
      set_hits[arr_set]++;
      if (arr_way_en != exp_mask) n_badmask++;
      if (arr_clr_valid) n_cv++;
      if (arr_clr_lock) n_cl++;
      if (arr_chk_we) n_cw++;
      if (arr_chk_we && arr_chk != exp_chk) n_badchk++;
    end
  end

  task automatic clear_mon(input logic [3:0] m, input logic [3:0] c);
    n_busy = 0; n_done = 0; n_wr = 0; n_cv = 0; n_cl = 0; n_cw = 0;
    n_badmask = 0; n_badchk = 0;
    for (int s = 0; s < 64; s++) set_hits[s] = 0;
    exp_mask = m;
    exp_chk  = c;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [31:0] v);
    @(posedge clk); #1;
    csr_wr = 1'b1; csr_wdata = v;
    @(posedge clk); #1;
    csr_wr = 1'b0; csr_wdata = '0;
  endtask

  task automatic pulse_abort();
    @(posedge clk); #1 abort_req = 1'b1;
    @(posedge clk); #1 abort_req = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  task automatic cover_sets(input string tag, input int n);
    int bad = 0;
    for (int s = 0; s < 64; s++)
      if (set_hits[s] != ((s < n) ? 1 : 0)) bad++;
    check(tag, bad, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 rdata after reset", csr_rdata, 32'h0);
    check("R1 outputs after reset", {busy, done, abort_flag, cache_en}, 4'b0);
    four_way_cfg = 1'b1;
    @(negedge clk);
    check("R3 geometry bit wide", csr_rdata, 32'h8);
  endtask

  task automatic t_inval_wide();
    clear_mon(4'hF, 4'h0);
    wr_reg(32'h2);
    @(negedge clk);
    check("R2 invalidate bit during walk", csr_rdata[1], 1'b1);
    wait_idle();
    check("R2 busy length wide", n_busy, 34);
    check("R2 done pulses", n_done, 1);
    check("R2 invalidate bit cleared", csr_rdata, 32'h8);
    check("R3 writes wide", n_wr, 32);
    cover_sets("R3 set coverage wide", 32);
    check("R3 way mask wide", n_badmask, 0);
    check("R4 valid cleared each write", n_cv, 32);
    check("R4 check bits dtype0", n_badchk, 0);
  endtask

  task automatic t_inval_narrow();
    four_way_cfg = 1'b0;
    clear_mon(4'h3, 4'h0);
    wr_reg(32'h2);
    wait_idle();
    check("R2 busy length narrow", n_busy, 66);
    check("R3 writes narrow", n_wr, 64);
    cover_sets("R3 set coverage narrow", 64);
    check("R3 way mask narrow", n_badmask, 0);
    check("R3 geometry bit narrow", csr_rdata, 32'h0);
    four_way_cfg = 1'b1;
  endtask

  task automatic t_dtype();
    clear_mon(4'hF, 4'hF);
    wr_reg(32'h0001_0002);
    repeat (5) @(posedge clk);
    wr_reg(32'h0);  // dtype back to 0 and invalidate 0, mid-walk
    wait_idle();
    check("R4 check bits from dtype latched at start", n_badchk, 0);
    check("R4 check writes", n_cw, 32);
    check("R5 write 0 mid-walk ignored", n_busy, 34);
    check("R4 dtype reads new value", csr_rdata[16], 1'b0);
  endtask

  task automatic t_rewrite_busy();
    clear_mon(4'hF, 4'h0);
    wr_reg(32'h2);
    repeat (10) @(posedge clk);
    wr_reg(32'h2);
    wait_idle();
    check("R5 rewrite no restart busy", n_busy, 34);
    check("R5 rewrite no restart writes", n_wr, 32);
    check("R5 rewrite single done", n_done, 1);
  endtask

  task automatic t_enable();
    clear_mon(4'hF, 4'h0);
    wr_reg(32'h3);
    @(negedge clk);
    check("R6 cache_en set", cache_en, 1'b1);
    wait_idle();
    check("R6 walk with enable", n_wr, 32);
    check("R6 rdata after walk", csr_rdata, 32'h9);
    wr_reg(32'h0);
    @(negedge clk);
    check("R6 cache_en cleared", cache_en, 1'b0);
  endtask

  task automatic t_flash();
    clear_mon(4'hF, 4'h0);
    wr_reg(32'h100);
    @(negedge clk);
    check("R7 lock-clear bit during walk", csr_rdata[8], 1'b1);
    wait_idle();
    check("R7 writes", n_wr, 32);
    check("R7 locks cleared", n_cl, 32);
    check("R7 valid untouched", n_cv, 0);
    check("R7 check untouched", n_cw, 0);
    check("R7 busy length", n_busy, 34);
    check("R7 bit self-clears", csr_rdata, 32'h8);
  endtask

  task automatic t_both();
    clear_mon(4'hF, 4'h0);
    wr_reg(32'h102);
    @(negedge clk);
    check("R10 lock-clear bit stays 0", csr_rdata[8], 1'b0);
    wait_idle();
    check("R10 invalidation ran", n_cv, 32);
  endtask

  task automatic t_abort_inval();
    int snap;
    clear_mon(4'hF, 4'h0);
    wr_reg(32'h2);
    repeat (6) @(posedge clk);
    pulse_abort();
    @(negedge clk);
    check("R8 busy low after abort", busy, 1'b0);
    check("R8 abort flag set", abort_flag, 1'b1);
    check("R8 rdata after abort", csr_rdata, 32'hC);
    check("R8 walk cut short", (n_wr < 32), 1'b1);
    check("R8 no done on abort", n_done, 0);
    snap = n_wr;
    repeat (5) @(negedge clk);
    check("R8 no writes after abort", n_wr, snap);
  endtask

  task automatic t_abort_sticky();
    wr_reg(32'h4);
    repeat (10) @(negedge clk);
    check("R9 write 1 keeps abort flag", abort_flag, 1'b1);
    wr_reg(32'h0);
    @(negedge clk);
    check("R9 write 0 clears abort flag", abort_flag, 1'b0);
  endtask

  task automatic t_abort_flash();
    clear_mon(4'hF, 4'h0);
    wr_reg(32'h100);
    repeat (4) @(posedge clk);
    pulse_abort();
    @(negedge clk);
    check("R8 lock-clear aborted flag", abort_flag, 1'b1);
    check("R8 lock-clear bit dropped", csr_rdata[8], 1'b0);
    wr_reg(32'h0);
  endtask

  task automatic t_abort_idle();
    pulse_abort();
    @(negedge clk);
    check("R8 idle abort ignored", {abort_flag, busy}, 2'b00);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; csr_wr = 1'b0; csr_wdata = '0; abort_req = 1'b0;
    four_way_cfg = 1'b0;
    clear_mon(4'hF, 4'h0);
    #21 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_inval_wide();
    t_inval_narrow();
    t_dtype();
    t_rewrite_busy();
    t_enable();
    t_flash();
    t_both();
    t_abort_inval();
    t_abort_sticky();
    t_abort_flash();
    t_abort_idle();
    finish_run();
  end
endmodule